// File: doc/BRIEF.md
# Dual-Role Byte Serial Port (SPI Master/Slave)

This block moves one byte at a time over a four-wire synchronous serial bus and can take either end of the link. In master role it produces the serial clock from the system clock at one of four fixed rates and exchanges a byte with the far end. In slave role it follows an external clock while an active-low select input is held low. Bytes travel most significant bit first, and the idle level of the clock and the edge that launches data are both selectable, so all four common clock modes are covered.

Software sees two registers behind a small read/write port. Writing the data register starts a transfer in master role, or preloads the byte to be returned on the next transfer in slave role. Reading it returns the last byte received and clears the completion flag. The control/status register holds role, clock idle level, clock phase and master rate, and shows the completion and busy flags. A one-cycle interrupt pulse marks every completed byte. Each bus line comes with an output-enable, so the direction of every pin follows the selected role. A clock-enable input pauses the transfer engine.

Top module: `spi_port`

## Requirements
- R1: After synchronous reset the control/status register reads 0x00 (slave role, clock idle low, phase 0, rate code 0, no flags), `irq` is low and `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R2: Writing the control register (`reg_addr` = 1) stores data bits [4:0] as role (bit 4, 1 = master), clock idle level (bit 3), clock phase (bit 2) and rate code (bits 1:0); reading it returns done at bit 7, busy at bit 6, 0 at bit 5 and the stored bits below; written bits [7:5] have no effect.
- R3: In master role `sck_oe` and `mosi_oe` are high and `miso_oe` is low; in slave role `sck_oe` and `mosi_oe` are low and `miso_oe` is high exactly while the synchronised select input is low.
- R4: In master role, while no transfer runs, `sck_o` rests at the clock idle level held in control bit 3.
- R5: A master transfer produces exactly 8 clock pulses whose period is 6, 12, 24 or 192 system clock cycles for rate codes 0, 1, 2 and 3.
- R6: Bytes go out most significant bit first; with phase 0 each bit is presented before the leading clock edge and sampled on it, with phase 1 each bit is launched on the leading edge and sampled on the trailing edge; in a master-to-slave link using any of the four idle-level/phase pairs, each side receives the byte the other side loaded.
- R7: When the eighth bit completes, done (status bit 7) is set and `irq` pulses for one cycle; a read of the data register (`reg_addr` = 0) returns the received byte one cycle later and clears done.
- R8: While a master transfer runs, busy (status bit 6) is high and writes to either register have no effect.
- R9: In slave role, a select that goes high before the eighth bit discards the partial byte: done is not set, and the next fully selected transfer exchanges whole bytes.
- R10: The rate code has no effect in slave role; the slave follows the external clock at any of the master rates.
- R11: While `ce` is low the transfer engine holds: `sck_o` does not change and the transfer resumes where it stopped once `ce` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the transfer engine |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = data register, 1 = control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| irq | output | 1 | One-cycle pulse per completed byte |
| sck_o | output | 1 | Serial clock out (master role) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave role) |
| mosi_o | output | 1 | Master-out line driven in master role |
| mosi_oe | output | 1 | Master-out line output enable |
| mosi_i | input | 1 | Master-out line received in slave role |
| miso_o | output | 1 | Slave-out line driven in slave role |
| miso_oe | output | 1 | Slave-out line output enable |
| miso_i | input | 1 | Slave-out line received in master role |
| ss_n_i | input | 1 | Active-low slave select input |

## Verification
Register reads return their value one cycle after the strobe, and the bench samples on the falling clock edge after that rising edge. In master role the first clock edge comes half a period after the write that starts the transfer, and done and `irq` appear on the same edge as the eighth trailing edge; in slave role every action lags the external clock by two cycles because of the input stage, so the slave's `irq` follows the master's by two cycles. The bench therefore watches each transfer cycle by cycle on falling edges, counts clock pulses and their spacing, keeps watching a fixed number of cycles past the master's pulse to catch the slave's, and only then reads the registers.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_cfg_t;

  localparam int CFG_W  = 5;
  localparam int STAT_W = 8;

  localparam logic REG_DATA = 1'b0;
  localparam logic REG_CTRL = 1'b1;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_port_pkg::*;
#(
  parameter int DIV0 = 6,
  parameter int DIV1 = 12,
  parameter int DIV2 = 24,
  parameter int DIV3 = 192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic       run,
  input  logic       cpol,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       lead,
  output logic       trail
);

  localparam int HMAX  = max4(DIV0 / 2, DIV1 / 2, DIV2 / 2, DIV3 / 2);
  localparam int CNT_W = (HMAX > 2) ? $clog2(HMAX) : 1;
  localparam int HALF [4] = '{DIV0 / 2, DIV1 / 2, DIV2 / 2, DIV3 / 2};

  logic [CNT_W-1:0] hc;
  logic [CNT_W-1:0] lim;
  logic             tick;

  always_comb lim = CNT_W'(HALF[rate] - 1);

  assign tick  = run & ce & (hc == lim);
  assign lead  = tick & (sck == cpol);
  assign trail = tick & (sck != cpol);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc  <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      hc  <= '0;
      sck <= cpol;
    end else if (ce) begin
      if (hc == lim) begin
        hc  <= '0;
        sck <= ~sck;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic cpol,
  input  logic sck_i,
  input  logic ss_n_i,
  input  logic mosi_i,
  output logic active,
  output logic lead,
  output logic trail,
  output logic din
);

  logic sck_a, sck_b, ss_a, mosi_a;
  logic edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_a  <= 1'b0;
      sck_b  <= 1'b0;
      ss_a   <= 1'b1;
      mosi_a <= 1'b0;
    end else if (ce) begin
      sck_a  <= sck_i;
      sck_b  <= sck_a;
      ss_a   <= ss_n_i;
      mosi_a <= mosi_i;
    end
  end

  assign active    = ~ss_a;
  assign edge_seen = ce & active & (sck_a ^ sck_b);
  assign lead      = edge_seen & (sck_a != cpol);
  assign trail     = edge_seen & (sck_a == cpol);
  assign din       = mosi_a;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         cpha,
  input  logic         lead,
  input  logic         trail,
  input  logic         din,
  output logic         dout,
  output logic         done,
  output logic [W-1:0] rx_byte
);

  localparam int CW = $clog2(W);

  logic [W-1:0]  txsh, rxsh;
  logic [CW-1:0] cnt;
  logic          launch, samp;

  assign launch  = cpha ? lead : trail;
  assign samp    = cpha ? trail : lead;
  assign done    = trail & (cnt == CW'(W - 1));
  assign rx_byte = samp ? {rxsh[W-2:0], din} : rxsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      txsh <= '0;
      rxsh <= '0;
      cnt  <= '0;
      dout <= 1'b0;
    end else if (load) begin
      txsh <= cpha ? load_val : (load_val << 1);
      rxsh <= '0;
      cnt  <= '0;
      dout <= load_val[W-1];
    end else begin
      if (samp)   rxsh <= {rxsh[W-2:0], din};
      if (launch) begin
        dout <= txsh[W-1];
        txsh <= txsh << 1;
      end
      if (trail)  cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV0   = 6,
  parameter int DIV1   = 12,
  parameter int DIV2   = 24,
  parameter int DIV3   = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i,
  input  logic              ss_n_i
);

  spi_cfg_t          cfg_q;
  logic              busy_q, done_q, irq_q;
  logic [DATA_W-1:0] pre_q, rx_q, rdata_q;
  logic [DATA_W-1:0] status;

  logic wr_data, wr_ctrl, rd_data, m_start;
  logic g_sck, g_lead, g_trail;
  logic s_active, s_lead, s_trail, s_din;
  logic c_load, c_lead, c_trail, c_din, c_dout, c_done;
  logic [DATA_W-1:0] c_load_val, c_rx;

  assign wr_data = reg_wr & (reg_addr == REG_DATA);
  assign wr_ctrl = reg_wr & (reg_addr == REG_CTRL);
  assign rd_data = reg_rd & (reg_addr == REG_DATA);
  assign m_start = wr_data & cfg_q.master & ~busy_q;

  assign status = DATA_W'({done_q, busy_q, 1'b0, cfg_q});

  spi_sck_gen #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) u_gen (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .run   (busy_q),
    .cpol  (cfg_q.cpol),
    .rate  (cfg_q.rate),
    .sck   (g_sck),
    .lead  (g_lead),
    .trail (g_trail)
  );

  spi_slave_front u_front (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .cpol   (cfg_q.cpol),
    .sck_i  (sck_i),
    .ss_n_i (ss_n_i),
    .mosi_i (mosi_i),
    .active (s_active),
    .lead   (s_lead),
    .trail  (s_trail),
    .din    (s_din)
  );

  always_comb begin
    if (cfg_q.master) begin
      c_load     = m_start;
      c_load_val = reg_wdata;
      c_lead     = g_lead;
      c_trail    = g_trail;
      c_din      = miso_i;
    end else begin
      c_load     = ~s_active | c_done;
      c_load_val = pre_q;
      c_lead     = s_lead;
      c_trail    = s_trail;
      c_din      = s_din;
    end
  end

  spi_shift_core #(.W(DATA_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load     (c_load),
    .load_val (c_load_val),
    .cpha     (cfg_q.cpha),
    .lead     (c_lead),
    .trail    (c_trail),
    .din      (c_din),
    .dout     (c_dout),
    .done     (c_done),
    .rx_byte  (c_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      pre_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      rx_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl && !busy_q) cfg_q <= reg_wdata[CFG_W-1:0];
      if (wr_data && !busy_q) pre_q <= reg_wdata;
      if (m_start)                     busy_q <= 1'b1;
      else if (c_done && cfg_q.master) busy_q <= 1'b0;
      if (c_done)       done_q <= 1'b1;
      else if (rd_data) done_q <= 1'b0;
      irq_q <= c_done;
      if (c_done) rx_q <= c_rx;
      if (reg_rd) rdata_q <= (reg_addr == REG_CTRL) ? status : rx_q;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
  assign sck_o     = g_sck;
  assign sck_oe    = cfg_q.master;
  assign mosi_o    = c_dout;
  assign mosi_oe   = cfg_q.master;
  assign miso_o    = c_dout;
  assign miso_oe   = ~cfg_q.master & s_active;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     ce,
  input logic     irq,
  input logic     sck_o,
  input logic     sck_oe,
  input logic     reg_wr,
  input logic     reg_addr,
  input logic     busy,
  input logic     done,
  input spi_cfg_t cfg
);

  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> done); // R7

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R7

  AST_IDLE_AT_CPOL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (sck_o == cfg.cpol)); // R4

  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!ce && busy) |=> $stable(sck_o)); // R11

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && reg_addr) |=> $stable(cfg)); // R8

  AST_BUSY_DRIVES_SCK: assert property (@(posedge clk) disable iff (rst)
    busy |-> sck_oe); // R3

endmodule

bind spi_port spi_port_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .ce       (ce),
  .irq      (irq),
  .sck_o    (sck_o),
  .sck_oe   (sck_oe),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .busy     (busy_q),
  .done     (done_q),
  .cfg      (cfg_q)
);

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ce, ss_n;
  logic m_wr, m_rd, m_addr, s_wr, s_rd, s_addr;
  logic [7:0] m_wdata, s_wdata, m_rdata, s_rdata;
  logic m_irq, m_sck_o, m_sck_oe, m_mosi_o, m_mosi_oe, m_miso_o, m_miso_oe;
  logic s_irq, s_sck_o, s_sck_oe, s_mosi_o, s_mosi_oe, s_miso_o, s_miso_oe;
  logic link_miso;

  assign link_miso = s_miso_oe ? s_miso_o : 1'b1;

  spi_port dut_i (
    .clk(clk), .rst(rst), .ce(ce),
    .reg_wr(m_wr), .reg_rd(m_rd), .reg_addr(m_addr), .reg_wdata(m_wdata), .reg_rdata(m_rdata),
    .irq(m_irq), .sck_o(m_sck_o), .sck_oe(m_sck_oe), .sck_i(1'b0),
    .mosi_o(m_mosi_o), .mosi_oe(m_mosi_oe), .mosi_i(1'b0),
    .miso_o(m_miso_o), .miso_oe(m_miso_oe), .miso_i(link_miso), .ss_n_i(1'b1)
  );

  spi_port slv_i (
    .clk(clk), .rst(rst), .ce(ce),
    .reg_wr(s_wr), .reg_rd(s_rd), .reg_addr(s_addr), .reg_wdata(s_wdata), .reg_rdata(s_rdata),
    .irq(s_irq), .sck_o(s_sck_o), .sck_oe(s_sck_oe), .sck_i(m_sck_o),
    .mosi_o(s_mosi_o), .mosi_oe(s_mosi_oe), .mosi_i(m_mosi_o),
    .miso_o(s_miso_o), .miso_oe(s_miso_oe), .miso_i(1'b0), .ss_n_i(ss_n)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input bit slave, input logic a, input logic [7:0] d);
    @(negedge clk);
    if (slave) begin s_wr = 1'b1; s_addr = a; s_wdata = d; end
    else       begin m_wr = 1'b1; m_addr = a; m_wdata = d; end
    @(negedge clk);
    s_wr = 1'b0;
    m_wr = 1'b0;
  endtask

  task automatic reg_read(input bit slave, input logic a, output logic [7:0] d);
    @(negedge clk);
    if (slave) begin s_rd = 1'b1; s_addr = a; end
    else       begin m_rd = 1'b1; m_addr = a; end
    @(negedge clk);
    s_rd = 1'b0;
    m_rd = 1'b0;
    d = slave ? s_rdata : m_rdata;
  endtask

  // Full master-to-slave exchange with pin-level monitoring
  task automatic exchange(input logic [7:0] mcfg, input logic [7:0] mb, input logic [7:0] sb,
                          input int exp_period);
    logic [7:0] v;
    logic prev;
    int cyc, rises, t2, t3, mi, si, after, toggles;
    logic first_mosi;
    reg_write(1'b1, 1'b0, sb);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    reg_write(1'b0, 1'b0, mb);
    prev = m_sck_o;
    cyc = 0; rises = 0; t2 = 0; t3 = 0; mi = 0; si = 0; after = 0; toggles = 0;
    first_mosi = 1'b0;
    while (after < 12 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (m_sck_o != prev) begin
        toggles++;
        if (toggles == 1) first_mosi = m_mosi_o;
        if (m_sck_o) begin
          rises++;
          if (rises == 2) t2 = cyc;
          if (rises == 3) t3 = cyc;
        end
      end
      prev = m_sck_o;
      if (m_irq) mi++;
      if (s_irq) si++;
      if (mi > 0) after++;
    end
    chk(rises == 8, "R5 pulse count", rises, 8);
    chk((t3 - t2) == exp_period, "R5 SCK period", t3 - t2, exp_period);
    chk(first_mosi == mb[7], "R6 MSB first on wire", first_mosi, mb[7]);
    chk(mi == 1, "R7 master irq pulses", mi, 1);
    chk(si == 1, "R7 slave irq pulses", si, 1);
    reg_read(1'b0, 1'b1, v);
    chk(v == (8'h80 | mcfg), "R7 master done set", v, 8'h80 | mcfg);
    reg_read(1'b0, 1'b0, v);
    chk(v == sb, "R6 master received", v, sb);
    reg_read(1'b0, 1'b1, v);
    chk(v == mcfg, "R7 master done cleared", v, mcfg);
    reg_read(1'b1, 1'b0, v);
    chk(v == mb, "R6 R10 slave received", v, mb);
    reg_read(1'b1, 1'b1, v);
    chk(v[7] == 1'b0, "R7 slave done cleared", v, 0);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, mcfg, scfg, mb, sb;
    logic held;
    bit stable_ok;
    rst = 1'b1; ce = 1'b1; ss_n = 1'b1;
    m_wr = 0; m_rd = 0; m_addr = 0; m_wdata = 0;
    s_wr = 0; s_rd = 0; s_addr = 0; s_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(m_irq == 1'b0 && s_irq == 1'b0, "R1 irq low", m_irq, 0);
    chk({m_sck_oe, m_mosi_oe, m_miso_oe} == 3'b000, "R1 enables low", {m_sck_oe, m_mosi_oe, m_miso_oe}, 0);
    reg_read(1'b0, 1'b1, v);
    chk(v == 8'h00, "R1 status after reset", v, 0);
    reg_read(1'b1, 1'b1, v);
    chk(v == 8'h00, "R1 slave status after reset", v, 0);

    // R2 control store, upper bits ignored
    reg_write(1'b0, 1'b1, 8'hF7);
    reg_read(1'b0, 1'b1, v);
    chk(v == 8'h17, "R2 control readback", v, 8'h17);

    // R3 directions
    chk({m_sck_oe, m_mosi_oe, m_miso_oe} == 3'b110, "R3 master enables", {m_sck_oe, m_mosi_oe, m_miso_oe}, 3'b110);
    ss_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({s_sck_oe, s_mosi_oe, s_miso_oe} == 3'b001, "R3 slave selected enables", {s_sck_oe, s_mosi_oe, s_miso_oe}, 3'b001);
    ss_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_miso_oe == 1'b0, "R3 slave deselected miso_oe", s_miso_oe, 0);

    // Sweep of all idle-level/phase pairs and all rates (R4 R5 R6 R10)
    for (int mode = 0; mode < 4; mode++) begin
      for (int rate = 0; rate < 4; rate++) begin
        mcfg = 8'h10 | 8'(mode << 2) | 8'(rate);
        scfg = 8'(mode << 2) | 8'(3 - rate);
        reg_write(1'b0, 1'b1, mcfg);
        reg_write(1'b1, 1'b1, scfg);
        repeat (2) @(negedge clk);
        chk(m_sck_o == mcfg[3], "R4 idle level", m_sck_o, mcfg[3]);
        mb = 8'h96 ^ 8'(mode * 16 + rate * 59);
        sb = {mb[3:0], mb[7:4]} ^ 8'h5A;
        exchange(mcfg, mb, sb, (rate == 0) ? 6 : (rate == 1) ? 12 : (rate == 2) ? 24 : 192);
      end
    end

    // R8 writes ignored while busy
    mcfg = 8'h13;
    reg_write(1'b0, 1'b1, mcfg);
    reg_write(1'b1, 1'b1, 8'h00);
    reg_write(1'b1, 1'b0, 8'hC3);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    reg_write(1'b0, 1'b0, 8'h3C);
    reg_write(1'b0, 1'b1, 8'h08);
    reg_write(1'b0, 1'b0, 8'h00);
    reg_read(1'b0, 1'b1, v);
    chk(v == (8'h40 | mcfg), "R8 busy and control unchanged", v, 8'h40 | mcfg);
    for (int i = 0; i < 3000 && !m_irq; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    reg_read(1'b0, 1'b0, v);
    chk(v == 8'hC3, "R8 master data after ignored writes", v, 8'hC3);
    reg_read(1'b1, 1'b0, v);
    chk(v == 8'h3C, "R8 slave got original byte", v, 8'h3C);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 clock enable freeze
    reg_write(1'b1, 1'b0, 8'h81);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    reg_write(1'b0, 1'b0, 8'h7E);
    repeat (100) @(negedge clk);
    ce = 1'b0;
    @(negedge clk);
    held = m_sck_o;
    stable_ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (m_sck_o != held) stable_ok = 1'b0;
    end
    chk(stable_ok, "R11 SCK held while ce low", stable_ok, 1);
    reg_read(1'b0, 1'b1, v);
    chk(v[6] == 1'b1, "R11 still busy while ce low", v[6], 1);
    ce = 1'b1;
    for (int i = 0; i < 3000 && !m_irq; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    reg_read(1'b0, 1'b0, v);
    chk(v == 8'h81, "R11 master data after resume", v, 8'h81);
    reg_read(1'b1, 1'b0, v);
    chk(v == 8'h7E, "R11 slave data after resume", v, 8'h7E);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 select dropped mid-byte
    mcfg = 8'h11;
    reg_write(1'b0, 1'b1, mcfg);
    reg_write(1'b1, 1'b1, 8'h00);
    reg_write(1'b1, 1'b0, 8'hE4);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    reg_write(1'b0, 1'b0, 8'h5B);
    repeat (50) @(negedge clk);
    ss_n = 1'b1;
    for (int i = 0; i < 3000 && !m_irq; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    reg_read(1'b1, 1'b1, v);
    chk(v == 8'h00, "R9 no slave done after abort", v, 8'h00);
    chk(s_miso_oe == 1'b0, "R9 R3 slave released miso", s_miso_oe, 0);
    reg_read(1'b0, 1'b0, v);
    exchange(mcfg, 8'hD2, 8'h4F, 12);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule